// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block carries an already recognized interrupt into its handler. When a request arrives while the sequencer is free, it captures the current status word, the return program counter and the supervisor stack pointer, then spends a fixed number of bus-quiet clocks building the new status word. The new word enters supervisor state, leaves trace off and raises the interrupt mask to the serviced level.

It then drives a fixed series of operations through a simple word-wide bus master and a separate acknowledge unit. First the low half of the return PC is pushed. Then the acknowledge runs, followed by a short quiet window to settle the vector number. After that come the pushes of the saved status word and the high half of the return PC, two vector-table reads, and the first opcode fetch of the handler. When the fetch completes, the sequencer hands the new PC and the lowered stack pointer to the core and becomes free again. Each operation is one request held high until a one-cycle done answer.

Top module: `irq_entry_seq`

## Requirements
- R1: `busy` rises in the cycle after a request is accepted while free, stays high until the final write cycle, and falls in the cycle after it. While free, no bus request, acknowledge request or register write is issued.
- R2: After acceptance there are exactly six cycles with no bus or acknowledge request. `sr_we` is high for exactly one of them, the sixth, and a bus write request follows at once.
- R3: `sr_out` is the captured status word with bit 13 (supervisor) set, bit 15 (trace) cleared, bits 10:8 (mask) replaced by the level, and all other bits kept.
- R4: Operations come in this order: write, acknowledge, write, write, read, read, fetch. `bus_op` encodes them as 00 write, 01 data read and 10 instruction fetch. A request holds its address until done, and bus and acknowledge requests never overlap.
- R5: Stack pushes use the captured SP. PC[15:0] goes to SP-2, then the captured status word goes to SP-6, then PC[31:16] goes to SP-4.
- R6: `iack_level` carries the serviced level while `iack_req` is high. After `iack_done`, four cycles pass with no request before the status push.
- R7: If `iack_auto` is high with `iack_done`, the vector number is 0x18 plus the level and `iack_vector` is ignored. Otherwise the vector number is `iack_vector`.
- R8: The vector reads go to vector*4 and then vector*4+2. The new PC is {first word, second word}, and the fetch goes to the new PC.
- R9: In the cycle after the fetch is done, `pc_we` and `sp_we` are high for one cycle, with `pc_out` equal to the new PC and `sp_out` equal to captured SP minus 6, wrapping modulo 2^32.
- R10: Requests, level changes and changes on `sr_in`, `pc_in` and `sp_in` while busy have no effect on any operation or result.
- R11: After reset the sequencer is free, with every request and write strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Recognized interrupt request |
| irq_level | input | 3 | Level of the request |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Return program counter |
| sp_in | input | 32 | Current supervisor stack pointer |
| busy | output | 1 | Entry sequence in progress |
| sr_out | output | 16 | New status word |
| sr_we | output | 1 | Write strobe for the new status word |
| pc_out | output | 32 | Handler program counter |
| pc_we | output | 1 | Write strobe for the PC |
| sp_out | output | 32 | New supervisor stack pointer |
| sp_we | output | 1 | Write strobe for the stack pointer |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | Operation: 00 write, 01 read, 10 fetch |
| bus_addr | output | 32 | Byte address of the word |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with done |
| bus_done | input | 1 | One-cycle completion of the bus operation |
| iack_req | output | 1 | Acknowledge request |
| iack_level | output | 3 | Level being acknowledged |
| iack_auto | input | 1 | Acknowledge ended as autovectored |
| iack_vector | input | 8 | Supplied vector number |
| iack_done | input | 1 | One-cycle acknowledge completion |

## Verification
The bench builds the block with its default parameters: 16-bit words, six quiet clocks for the status update, four for vector settling, and an autovector base of 0x18. These values make every gap, address and mask position directly comparable with hand-computed frames. A stack pointer of 4 forces the frame to wrap below address zero. Vector 0xFF reaches the top of the vector table, and bus and acknowledge latencies from zero to several cycles stretch each handshake. A garbage vector supplied with an autovectored answer and a burst of conflicting requests while busy show that both leave the frame untouched.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes a 16-bit status word with supervisor, trace and mask fields at fixed bits.
package irq_seq_pkg;

    localparam int SR_W       = 16;
    localparam int SR_S_BIT   = 13;
    localparam int SR_T_BIT   = 15;
    localparam int SR_MASK_LO = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SAVE, ST_PUSH_PCL, ST_ACK, ST_JUST,
        ST_PUSH_SR, ST_PUSH_PCH, ST_RD_VH, ST_RD_VL, ST_FETCH, ST_WRAP
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_FETCH = 2'b10
    } bus_op_t;

    // Build the status word used while the handler runs
    function automatic logic [SR_W-1:0] enter_sr(input logic [SR_W-1:0] s,
                                                 input logic [2:0] lvl);
        logic [SR_W-1:0] r;
        r = s;
        r[SR_S_BIT] = 1'b1;
        r[SR_T_BIT] = 1'b0;
        r[SR_MASK_LO +: 3] = lvl;
        return r;
    endfunction

endpackage

// File: rtl/irq_seq_ctrl.sv
// Sequencing state machine for interrupt entry.
// It walks the fixed step order, counts the quiet windows and reports acceptance.
// Assumes done inputs are single-cycle pulses given only while the matching request is high.
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int SAVE_CLKS = 6,
    parameter int JUST_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       bus_done,
    input  logic       iack_done,
    output seq_state_t state,
    output logic       accept,
    output logic       save_last
);

    localparam int MAX_CLKS = (SAVE_CLKS > JUST_CLKS) ? SAVE_CLKS : JUST_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             save_end;
    logic             just_end;

    // Detect the last cycle of each quiet window
    always_comb begin
        save_end  = (cnt == CNT_W'(SAVE_CLKS - 1));
        just_end  = (cnt == CNT_W'(JUST_CLKS - 1));
        accept    = (state == ST_IDLE) && irq_req;
        save_last = (state == ST_SAVE) && save_end;
    end

    // Next step selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (irq_req)   nxt = ST_SAVE;
            ST_SAVE:     if (save_end)  nxt = ST_PUSH_PCL;
            ST_PUSH_PCL: if (bus_done)  nxt = ST_ACK;
            ST_ACK:      if (iack_done) nxt = ST_JUST;
            ST_JUST:     if (just_end)  nxt = ST_PUSH_SR;
            ST_PUSH_SR:  if (bus_done)  nxt = ST_PUSH_PCH;
            ST_PUSH_PCH: if (bus_done)  nxt = ST_RD_VH;
            ST_RD_VH:    if (bus_done)  nxt = ST_RD_VL;
            ST_RD_VL:    if (bus_done)  nxt = ST_FETCH;
            ST_FETCH:    if (bus_done)  nxt = ST_WRAP;
            ST_WRAP:                    nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Quiet-window counter, cleared on every step change
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (nxt != state)
            cnt <= '0;
        else if (state == ST_SAVE || state == ST_JUST)
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/irq_seq_ctx.sv
// Context capture for interrupt entry.
// Holds the status word, PC, SP and level taken at acceptance, plus the vector number and table words.
// Assumes the PC is exactly two bus words wide.
module irq_seq_ctx
    import irq_seq_pkg::*;
#(
    parameter int DW        = 16,
    parameter int VEC_W     = 8,
    parameter int AUTO_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic              bus_done,
    input  logic              iack_done,
    input  logic [2:0]        irq_level,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [2*DW-1:0]   sp_in,
    input  logic              iack_auto,
    input  logic [VEC_W-1:0]  iack_vector,
    input  logic [DW-1:0]     bus_rdata,
    output logic [SR_W-1:0]   sr_copy,
    output logic [SR_W-1:0]   sr_new,
    output logic [2*DW-1:0]   pc_save,
    output logic [2*DW-1:0]   sp_save,
    output logic [2:0]        level,
    output logic [2*DW-1:0]   vec_addr,
    output logic [2*DW-1:0]   pc_new
);

    localparam int AW = 2 * DW;

    logic [VEC_W-1:0] vec;
    logic [DW-1:0]    vhi;
    logic [DW-1:0]    vlo;
    logic [VEC_W-1:0] vec_pick;

    // Choose between the internal and the supplied vector number
    always_comb begin
        vec_pick = iack_auto ? (VEC_W'(AUTO_BASE) + VEC_W'(level)) : iack_vector;
        sr_new   = enter_sr(sr_copy, level);
        vec_addr = {{(AW-VEC_W-2){1'b0}}, vec, 2'b00};
        pc_new   = {vhi, vlo};
    end

    // Snapshot of the interrupted context at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_copy <= '0;
            pc_save <= '0;
            sp_save <= '0;
            level   <= '0;
        end else if (accept) begin
            sr_copy <= sr_in;
            pc_save <= pc_in;
            sp_save <= sp_in;
            level   <= irq_level;
        end
    end

    // Vector number latched when the acknowledge completes
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec <= '0;
        else if (state == ST_ACK && iack_done)
            vec <= vec_pick;
    end

    // Vector table words latched as each read completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vhi <= '0;
            vlo <= '0;
        end else if (bus_done) begin
            if (state == ST_RD_VH) vhi <= bus_rdata;
            if (state == ST_RD_VL) vlo <= bus_rdata;
        end
    end

endmodule

// File: rtl/irq_seq_busdrv.sv
// Bus and acknowledge request decoder for interrupt entry.
// Maps each step to its operation, address and write data. Purely combinational.
// Assumes byte addressing with word-aligned stack and table entries.
module irq_seq_busdrv
    import irq_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  seq_state_t        state,
    input  logic [SR_W-1:0]   sr_copy,
    input  logic [2*DW-1:0]   pc_save,
    input  logic [2*DW-1:0]   sp_save,
    input  logic [2*DW-1:0]   vec_addr,
    input  logic [2*DW-1:0]   pc_new,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [2*DW-1:0]   bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              iack_req
);

    localparam int AW = 2 * DW;

    // Step to operation decode
    always_comb begin
        bus_req   = 1'b0;
        bus_op    = OP_WRITE;
        bus_addr  = '0;
        bus_wdata = '0;
        iack_req  = 1'b0;
        unique case (state)
            ST_PUSH_PCL: begin
                bus_req   = 1'b1;
                bus_addr  = sp_save - AW'(2);
                bus_wdata = pc_save[DW-1:0];
            end
            ST_ACK: iack_req = 1'b1;
            ST_PUSH_SR: begin
                bus_req   = 1'b1;
                bus_addr  = sp_save - AW'(6);
                bus_wdata = DW'(sr_copy);
            end
            ST_PUSH_PCH: begin
                bus_req   = 1'b1;
                bus_addr  = sp_save - AW'(4);
                bus_wdata = pc_save[AW-1:DW];
            end
            ST_RD_VH: begin
                bus_req  = 1'b1;
                bus_op   = OP_READ;
                bus_addr = vec_addr;
            end
            ST_RD_VL: begin
                bus_req  = 1'b1;
                bus_op   = OP_READ;
                bus_addr = vec_addr + AW'(2);
            end
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_op   = OP_FETCH;
                bus_addr = pc_new;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt exception entry sequencer, top level.
// Connects the step controller, the context store and the request decoder.
// Assumes a word-wide bus master and a separate acknowledge unit, both with request/done handshakes.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int DW        = 16,
    parameter int VEC_W     = 8,
    parameter int AUTO_BASE = 24,
    parameter int SAVE_CLKS = 6,
    parameter int JUST_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [2:0]        irq_level,
    input  logic [15:0]       sr_in,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [2*DW-1:0]   sp_in,
    output logic              busy,
    output logic [15:0]       sr_out,
    output logic              sr_we,
    output logic [2*DW-1:0]   pc_out,
    output logic              pc_we,
    output logic [2*DW-1:0]   sp_out,
    output logic              sp_we,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [2*DW-1:0]   bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_done,
    output logic              iack_req,
    output logic [2:0]        iack_level,
    input  logic              iack_auto,
    input  logic [VEC_W-1:0]  iack_vector,
    input  logic              iack_done
);

    localparam int AW = 2 * DW;

    seq_state_t      state;
    logic            accept;
    logic            save_last;
    logic [15:0]     sr_copy;
    logic [2*DW-1:0] pc_save;
    logic [2*DW-1:0] sp_save;
    logic [2:0]      level;
    logic [2*DW-1:0] vec_addr;
    logic [2*DW-1:0] pc_new;

    irq_seq_ctrl #(
        .SAVE_CLKS (SAVE_CLKS),
        .JUST_CLKS (JUST_CLKS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .bus_done  (bus_done),
        .iack_done (iack_done),
        .state     (state),
        .accept    (accept),
        .save_last (save_last)
    );

    irq_seq_ctx #(
        .DW        (DW),
        .VEC_W     (VEC_W),
        .AUTO_BASE (AUTO_BASE)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .accept      (accept),
        .bus_done    (bus_done),
        .iack_done   (iack_done),
        .irq_level   (irq_level),
        .sr_in       (sr_in),
        .pc_in       (pc_in),
        .sp_in       (sp_in),
        .iack_auto   (iack_auto),
        .iack_vector (iack_vector),
        .bus_rdata   (bus_rdata),
        .sr_copy     (sr_copy),
        .sr_new      (sr_out),
        .pc_save     (pc_save),
        .sp_save     (sp_save),
        .level       (level),
        .vec_addr    (vec_addr),
        .pc_new      (pc_new)
    );

    irq_seq_busdrv #(
        .DW (DW)
    ) u_busdrv (
        .state     (state),
        .sr_copy   (sr_copy),
        .pc_save   (pc_save),
        .sp_save   (sp_save),
        .vec_addr  (vec_addr),
        .pc_new    (pc_new),
        .bus_req   (bus_req),
        .bus_op    (bus_op),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .iack_req  (iack_req)
    );

    // Core-facing strobes and results
    always_comb begin
        busy       = (state != ST_IDLE);
        sr_we      = save_last;
        pc_we      = (state == ST_WRAP);
        sp_we      = (state == ST_WRAP);
        pc_out     = pc_new;
        sp_out     = sp_save - AW'(6);
        iack_level = level;
    end

endmodule

// File: rtl/irq_entry_seq_chk.sv
// Protocol checker for the interrupt entry sequencer, bound to the top level.
// Assumes only the ports of the top level are visible.
module irq_entry_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          bus_req,
    input logic          bus_done,
    input logic [1:0]    bus_op,
    input logic [AW-1:0] bus_addr,
    input logic          iack_req,
    input logic [2:0]    iack_level,
    input logic          sr_we,
    input logic [15:0]   sr_out,
    input logic          pc_we
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !iack_req && !sr_we && !pc_we)); // R1
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pc_we) |=> busy); // R1
    AST_SR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> !sr_we); // R2
    AST_SR_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> (bus_req && bus_op == 2'b00)); // R2
    AST_SR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> (sr_out[13] && !sr_out[15])); // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && iack_req)); // R4
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_op))); // R4
    AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        iack_req |-> (iack_level == sr_out[10:8])); // R6
    AST_WRAP_END: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (!busy && !pc_we)); // R9

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(2*DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .bus_req    (bus_req),
    .bus_done   (bus_done),
    .bus_op     (bus_op),
    .bus_addr   (bus_addr),
    .iack_req   (iack_req),
    .iack_level (iack_level),
    .sr_we      (sr_we),
    .sr_out     (sr_out),
    .pc_we      (pc_we)
);

// File: tb/irq_entry_seq_bench.sv
// Scoreboard bench: the driver task queues the expected frame, the negedge monitor answers and compares.
module irq_entry_seq_bench;

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 read, 2 fetch, 3 acknowledge
        logic [31:0] addr;   // level for acknowledge
        logic [15:0] data;
        logic [7:0]  gap;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_level = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] sp_in = '0;
    logic        busy, sr_we, pc_we, sp_we, bus_req, iack_req;
    logic [15:0] sr_out, bus_wdata;
    logic [31:0] pc_out, sp_out, bus_addr;
    logic [1:0]  bus_op;
    logic [2:0]  iack_level;
    logic [15:0] bus_rdata = '0;
    logic        bus_done = 1'b0;
    logic        iack_auto = 1'b0;
    logic [7:0]  iack_vector = '0;
    logic        iack_done = 1'b0;

    int checks = 0;
    int errors = 0;
    item_t sbq[$];
    int idle_cnt = 0;
    bit seen = 0;
    int bw = 0, aw = 0;
    int blat = 0, alat = 0;
    bit a_auto = 0;
    logic [7:0]  a_vec = '0;
    logic [15:0] exp_sr = '0;
    logic [31:0] exp_pc = '0, exp_sp = '0;
    int sr_we_cnt = 0, pc_we_cnt = 0;

    always #5 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
        .sr_in(sr_in), .pc_in(pc_in), .sp_in(sp_in), .busy(busy),
        .sr_out(sr_out), .sr_we(sr_we), .pc_out(pc_out), .pc_we(pc_we),
        .sp_out(sp_out), .sp_we(sp_we), .bus_req(bus_req), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_done(bus_done), .iack_req(iack_req), .iack_level(iack_level),
        .iack_auto(iack_auto), .iack_vector(iack_vector), .iack_done(iack_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [31:0] a);
        return a[15:0] ^ 16'h3C5A ^ {a[23:16], a[31:24]};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor and responders: compare each new operation, then answer it
    always @(negedge clk) begin
        if (!rst_n) begin
            idle_cnt = 0; seen = 0; bw = 0; aw = 0;
            bus_done = 0; iack_done = 0;
        end else begin
            if (!busy) idle_cnt = 0;
            if ((bus_req || iack_req) && !seen) begin
                item_t it;
                seen = 1;
                if (sbq.size() == 0) begin
                    chk(0, "R4", "unexpected operation", {30'b0, bus_op}, 32'hFFFF);
                end else begin
                    it = sbq.pop_front();
                    if (it.kind == 2'd3) begin
                        chk(iack_req, "R4", "acknowledge expected", {31'b0, iack_req}, 1);
                        chk(iack_level == it.addr[2:0], "R6", "iack level", {29'b0, iack_level}, it.addr);
                    end else begin
                        chk(bus_req && bus_op == it.kind, "R4", "bus op kind", {30'b0, bus_op}, {30'b0, it.kind});
                        chk(bus_addr == it.addr, "R5 R8", "bus address", bus_addr, it.addr);
                        if (it.kind == 2'd0)
                            chk(bus_wdata == it.data, "R5", "write data", {16'b0, bus_wdata}, {16'b0, it.data});
                    end
                    chk(idle_cnt == int'(it.gap), "R2 R6", "quiet cycles before op", idle_cnt, {24'b0, it.gap});
                end
            end else if (busy && !bus_req && !iack_req) begin
                idle_cnt++;
            end
            if (sr_we) begin
                sr_we_cnt++;
                chk(sr_out == exp_sr, "R3", "new status word", {16'b0, sr_out}, {16'b0, exp_sr});
                chk(idle_cnt == 6, "R2", "sr_we in sixth quiet cycle", idle_cnt, 6);
            end
            if (pc_we) begin
                pc_we_cnt++;
                chk(pc_out == exp_pc, "R8 R9", "handler PC", pc_out, exp_pc);
                chk(sp_we && sp_out == exp_sp, "R9", "final SP", sp_out, exp_sp);
            end
            if (bus_req && !bus_done) begin
                if (bw >= blat) begin
                    bus_done = 1; bus_rdata = mem_word(bus_addr);
                    seen = 0; idle_cnt = 0; bw = 0;
                end else bw++;
            end else bus_done = 0;
            if (iack_req && !iack_done) begin
                if (aw >= alat) begin
                    iack_done = 1; iack_auto = a_auto; iack_vector = a_vec;
                    seen = 0; idle_cnt = 0; aw = 0;
                end else aw++;
            end else iack_done = 0;
        end
    end

    // Driver: queue the expected frame, raise the request, wait for completion
    task automatic run_irq(input logic [2:0] lvl, input logic [15:0] sr,
                           input logic [31:0] pc, input logic [31:0] sp,
                           input bit autov, input logic [7:0] vec_in,
                           input int bl, input int al, input bit spam);
        logic [7:0]  v;
        logic [31:0] va, npc;
        int guard;
        v   = autov ? (8'h18 + {5'b0, lvl}) : vec_in;
        va  = {22'b0, v, 2'b00};
        npc = {mem_word(va), mem_word(va + 32'd2)};
        sbq.push_back('{2'd0, sp - 32'd2, pc[15:0], 8'd6});
        sbq.push_back('{2'd3, {29'b0, lvl}, 16'h0, 8'd0});
        sbq.push_back('{2'd0, sp - 32'd6, sr, 8'd4});
        sbq.push_back('{2'd0, sp - 32'd4, pc[31:16], 8'd0});
        sbq.push_back('{2'd1, va, 16'h0, 8'd0});
        sbq.push_back('{2'd1, va + 32'd2, 16'h0, 8'd0});
        sbq.push_back('{2'd2, npc, 16'h0, 8'd0});
        exp_sr = (sr & ~16'h8700) | 16'h2000 | {5'b0, lvl, 8'b0};
        exp_pc = npc; exp_sp = sp - 32'd6;
        blat = bl; alat = al; a_auto = autov;
        a_vec = autov ? 8'hA7 : vec_in;
        sr_we_cnt = 0; pc_we_cnt = 0;
        @(negedge clk);
        irq_req = 1; irq_level = lvl; sr_in = sr; pc_in = pc; sp_in = sp;
        @(negedge clk);
        irq_req = 0;
        chk(busy, "R1", "busy after accept", {31'b0, busy}, 1);
        if (spam) begin  // R10: conflicting request and inputs while busy
            repeat (2) @(negedge clk);
            irq_req = 1; irq_level = ~lvl; sr_in = ~sr; pc_in = ~pc; sp_in = sp ^ 32'h00F0_0F00;
            repeat (8) @(negedge clk);
            irq_req = 0;
        end
        guard = 0;
        while (busy && guard < 2000) begin @(negedge clk); guard++; end
        chk(!busy, "R1", "busy cleared after fetch", {31'b0, busy}, 0);
        chk(sbq.size() == 0, "R4", "all operations issued", sbq.size(), 0);
        chk(sr_we_cnt == 1, "R2", "sr_we count", sr_we_cnt, 1);
        chk(pc_we_cnt == 1, "R9", "pc_we count", pc_we_cnt, 1);
        repeat (6) @(negedge clk);
        chk(!busy && !bus_req && !iack_req, "R10", "no restart after finish", {29'b0, busy, bus_req, iack_req}, 0);
        sbq.delete();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!busy && !bus_req && !iack_req && !sr_we && !pc_we && !sp_we, "R11", "reset outputs",
            {26'b0, busy, bus_req, iack_req, sr_we, pc_we, sp_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy, "R11", "free after reset", {31'b0, busy}, 0);
        // R7 vectored, R5 frame
        run_irq(3'd5, 16'h8715, 32'h0001_2344, 32'h0000_8000, 1'b0, 8'h40, 0, 0, 1'b0);
        // R7 autovectored with stretched handshakes, R10 ignored requests
        run_irq(3'd7, 16'h0000, 32'hDEAD_BEE0, 32'h0010_0000, 1'b1, 8'h00, 2, 3, 1'b1);
        run_irq(3'd1, 16'hFFFF, 32'h1234_5678, 32'h0000_1000, 1'b1, 8'h00, 1, 0, 1'b0);
        // R5 R9 stack wrap below zero, R8 top of vector table
        run_irq(3'd0, 16'h2300, 32'h0000_0002, 32'h0000_0004, 1'b0, 8'hFF, 4, 1, 1'b1);
        summary();
        $finish;
    end

endmodule